// File: doc/BRIEF.md
# Video RAM Access Timing Sequencer

This block shares a single video RAM among three users: a display controller that fetches screen data, a CPU/DMA port, and a refresh source. It runs on one master clock. It produces the phase strobes that open and close each display access. It also produces the mutually exclusive address-select signals, and uses them to steer one of three addresses onto the RAM address bus.

A display access opens when the display side requests it. The access lasts until a rising edge of the phase input is seen. A CPU request that waits during a display access is served in the slot that follows. Once every `REF_EVERY` display accesses, that slot is used for a refresh access instead, and the CPU keeps waiting. CPU and refresh slots each last `SLOT_CYC` clock cycles.

Top module: `vram_slot_seq`

## Requirements
- R1: `sync_n` is low for exactly the first clock cycle of each display access, and `disp_sel` is high in that same cycle.
- R2: `disp_sel` stays high from the start of a display access until it ends, and while it is high `ram_addr` equals `disp_addr`.
- R3: during a CPU slot `cpu_sel_n` is low for `SLOT_CYC` cycles (default 2), and `ram_addr` equals `cpu_addr` throughout.
- R4: during a display access, `adv_n` is low in any cycle where `phase_in` is high and was low at the previous clock edge. The display access ends at the next clock edge.
- R5: a CPU slot begins only at the clock edge that ends a display access, and only when `cpu_req` is high at that edge.
- R6: `cpu_wait` is high whenever `cpu_req` is high and no CPU slot is active, including during display and refresh accesses.
- R7: the end of every `REF_EVERY`-th display access (default 4) starts a refresh slot of `SLOT_CYC` cycles in place of a CPU slot. During it `ref_sel` is high and `ram_addr` equals the refresh counter. The counter starts at 0 and increments by one after each refresh slot.
- R8: at most one of `disp_sel`, `ref_sel`, `!cpu_sel_n` is active in any cycle. When none is active, `ram_addr` is 0.
- R9: a clock edge with `rst_n` low returns the block to idle: no select active, `sync_n` high, and the refresh counter and display-access count cleared. After reset, `cpu_req` alone grants nothing, and the first access granted is a display access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_in | input | 1 | Phase clock level; a rising edge closes a display access |
| disp_req | input | 1 | Display side requests an access |
| cpu_req | input | 1 | CPU/DMA side requests an access |
| disp_addr | input | AW | Display controller memory address |
| cpu_addr | input | AW | CPU address bus |
| sync_n | output | 1 | Low in the first cycle of a display access |
| adv_n | output | 1 | End-of-display sample, low when the access closes |
| disp_sel | output | 1 | Display address selected |
| cpu_sel_n | output | 1 | CPU address selected, active low |
| ref_sel | output | 1 | Refresh address selected |
| cpu_wait | output | 1 | Holds the CPU while its request is not being served |
| ram_addr | output | AW | Multiplexed RAM address |

## Verification
Two things can happen in the same cycle: the display access closes on a phase edge, and the slot that follows is handed to either the CPU or a refresh. At the fourth display access, the bench raises `phase_in` while `cpu_req` is high. It then checks three things: the next cycle is a refresh with the counter on `ram_addr`, `cpu_sel_n` stays high, and `cpu_wait` stays asserted. In a separate case, a phase edge that arrives in the first display cycle makes `sync_n` and `adv_n` low together. The bench checks that the access still closes cleanly after that one cycle.

// File: rtl/vras_pkg.sv
// Package: shared types for the video RAM access sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package vras_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DISP = 2'd1,
        ST_CPU  = 2'd2,
        ST_REF  = 2'd3
    } vras_state_e;
endpackage

// File: rtl/vras_phase_edge.sv
// Module: detects a rising edge of the phase level in the master clock domain.
// Assumes: phase_in is synchronous to clk; rise is combinational from phase_in.
module vras_phase_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_in,
    output logic rise
);
    logic ph_q;

    // hold the phase level seen at the last clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= phase_in;
    end

    // rising edge: high now, low at the previous edge
    assign rise = phase_in & ~ph_q;
endmodule

// File: rtl/vras_ctrl.sv
// Module: access-slot state machine. Opens display accesses, closes them on a
// phase edge, then grants a CPU or refresh slot of SLOT_CYC cycles.
// Assumes: one refresh replaces the CPU slot every REF_EVERY display accesses.
module vras_ctrl
    import vras_pkg::*;
#(
    parameter int REF_EVERY = 4,
    parameter int SLOT_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_rise,
    input  logic disp_req,
    input  logic cpu_req,
    output logic sync_n,
    output logic adv_n,
    output logic disp_sel,
    output logic cpu_sel_n,
    output logic ref_sel,
    output logic cpu_wait,
    output logic ref_inc
);
    localparam int CW = (REF_EVERY > 1) ? $clog2(REF_EVERY) : 1;
    localparam int SW = (SLOT_CYC  > 1) ? $clog2(SLOT_CYC)  : 1;

    vras_state_e   state;
    logic          first;
    logic [SW-1:0] slot;
    logic [CW-1:0] dcnt;
    logic          ref_due;
    logic          slot_last;

    assign ref_due   = (dcnt == CW'(REF_EVERY - 1));
    assign slot_last = (slot == SW'(SLOT_CYC - 1));

    // advance the slot state, the slot length counter and the display count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            first <= 1'b0;
            slot  <= '0;
            dcnt  <= '0;
        end else begin
            first <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (disp_req) begin
                        state <= ST_DISP;
                        first <= 1'b1;
                    end
                end
                ST_DISP: begin
                    if (ph_rise) begin
                        slot <= '0;
                        if (ref_due) begin
                            state <= ST_REF;
                            dcnt  <= '0;
                        end else begin
                            dcnt  <= dcnt + CW'(1);
                            state <= cpu_req ? ST_CPU : ST_IDLE;
                        end
                    end
                end
                ST_CPU, ST_REF: begin
                    if (slot_last) begin
                        state <= ST_IDLE;
                        slot  <= '0;
                    end else begin
                        slot <= slot + SW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // decode strobes and selects from the registered state
    always_comb begin
        disp_sel  = (state == ST_DISP);
        cpu_sel_n = (state != ST_CPU);
        ref_sel   = (state == ST_REF);
        sync_n    = ~((state == ST_DISP) & first);
        adv_n     = ~((state == ST_DISP) & ph_rise);
        cpu_wait  = cpu_req & (state != ST_CPU);
        ref_inc   = (state == ST_REF) & slot_last;
    end

    // R8: selects never overlap
    p_onehot_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disp_sel, ~cpu_sel_n, ref_sel}));

    // R1: the sync strobe only appears inside a display access
    p_sync_in_disp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |-> disp_sel);

    // R4: a phase edge during a display access ends it at the next edge
    p_disp_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_sel && !adv_n) |=> !disp_sel);

    // R2: without a phase edge the display access continues
    p_disp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_sel && !ph_rise) |=> disp_sel);

    // R5: a CPU slot begins only right after a display access closed with a request
    p_cpu_after_disp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_sel_n && $past(cpu_sel_n)) |->
            ($past(disp_sel) && $past(ph_rise) && $past(cpu_req)));
endmodule

// File: rtl/vras_ref_ctr.sv
// Module: refresh row address counter, steps once per completed refresh slot.
// Assumes: inc is a single-cycle pulse from the slot controller.
module vras_ref_ctr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    // step the refresh address after each refresh
    always_ff @(posedge clk) begin
        if (!rst_n)   addr <= '0;
        else if (inc) addr <= addr + AW'(1);
    end

    // R7: each refresh moves the address on by exactly one
    p_ref_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (addr == $past(addr) + AW'(1)));
endmodule

// File: rtl/vras_addr_mux.sv
// Module: steers the selected address onto the RAM address bus.
// Assumes: the three selects are mutually exclusive; with none set the bus is 0.
module vras_addr_mux #(
    parameter int AW = 8
) (
    input  logic          sel_disp,
    input  logic          sel_cpu,
    input  logic          sel_ref,
    input  logic [AW-1:0] disp_addr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [AW-1:0] ref_addr,
    output logic [AW-1:0] addr_out
);
    // AND-OR selection of the active source
    always_comb begin
        addr_out = ({AW{sel_disp}} & disp_addr)
                 | ({AW{sel_cpu}}  & cpu_addr)
                 | ({AW{sel_ref}}  & ref_addr);
    end
endmodule

// File: rtl/vram_slot_seq.sv
// Module: top of the video RAM access sequencer. Joins the phase edge
// detector, slot controller, refresh counter and address multiplexer.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module vram_slot_seq #(
    parameter int AW        = 8,
    parameter int REF_EVERY = 4,
    parameter int SLOT_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_in,
    input  logic          disp_req,
    input  logic          cpu_req,
    input  logic [AW-1:0] disp_addr,
    input  logic [AW-1:0] cpu_addr,
    output logic          sync_n,
    output logic          adv_n,
    output logic          disp_sel,
    output logic          cpu_sel_n,
    output logic          ref_sel,
    output logic          cpu_wait,
    output logic [AW-1:0] ram_addr
);
    logic          ph_rise;
    logic          ref_inc;
    logic [AW-1:0] ref_addr;

    vras_phase_edge i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_in (phase_in),
        .rise     (ph_rise)
    );

    vras_ctrl #(.REF_EVERY(REF_EVERY), .SLOT_CYC(SLOT_CYC)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph_rise   (ph_rise),
        .disp_req  (disp_req),
        .cpu_req   (cpu_req),
        .sync_n    (sync_n),
        .adv_n     (adv_n),
        .disp_sel  (disp_sel),
        .cpu_sel_n (cpu_sel_n),
        .ref_sel   (ref_sel),
        .cpu_wait  (cpu_wait),
        .ref_inc   (ref_inc)
    );

    vras_ref_ctr #(.AW(AW)) i_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_inc),
        .addr  (ref_addr)
    );

    vras_addr_mux #(.AW(AW)) i_mux (
        .sel_disp  (disp_sel),
        .sel_cpu   (~cpu_sel_n),
        .sel_ref   (ref_sel),
        .disp_addr (disp_addr),
        .cpu_addr  (cpu_addr),
        .ref_addr  (ref_addr),
        .addr_out  (ram_addr)
    );

    // R2: the display address reaches the RAM during a display access
    p_mux_disp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_sel |-> (ram_addr == disp_addr));

    // R3: the CPU address reaches the RAM during a CPU slot
    p_mux_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_sel_n |-> (ram_addr == cpu_addr));
endmodule

// File: tb/test_vram_slot_seq.sv
module test_vram_slot_seq;
    localparam int AW = 8;
    localparam logic [AW-1:0] DA = 8'hA5;
    localparam logic [AW-1:0] CA = 8'h3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          phase_in = 1'b0;
    logic          disp_req = 1'b0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] disp_addr = DA;
    logic [AW-1:0] cpu_addr = CA;
    logic          sync_n, adv_n, disp_sel, cpu_sel_n, ref_sel, cpu_wait;
    logic [AW-1:0] ram_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vram_slot_seq #(.AW(AW), .REF_EVERY(4), .SLOT_CYC(2)) i_vram_slot_seq (
        .clk(clk), .rst_n(rst_n), .phase_in(phase_in),
        .disp_req(disp_req), .cpu_req(cpu_req),
        .disp_addr(disp_addr), .cpu_addr(cpu_addr),
        .sync_n(sync_n), .adv_n(adv_n), .disp_sel(disp_sel),
        .cpu_sel_n(cpu_sel_n), .ref_sel(ref_sel), .cpu_wait(cpu_wait),
        .ram_addr(ram_addr)
    );

    // row: {disp_req, cpu_req, phase_in} {disp_sel, cpu_sel_n, ref_sel, sync_n, adv_n, cpu_wait} {ram_addr}
    localparam int NV = 18;
    localparam logic [16:0] VEC [NV] = '{
        {3'b000, 6'b010110, 8'h00},
        {3'b110, 6'b010111, 8'h00},
        {3'b010, 6'b110011, DA},
        {3'b011, 6'b110101, DA},
        {3'b111, 6'b000110, CA},
        {3'b100, 6'b000110, CA},
        {3'b100, 6'b010110, 8'h00},
        {3'b001, 6'b110000, DA},
        {3'b101, 6'b010110, 8'h00},
        {3'b010, 6'b110011, DA},
        {3'b011, 6'b110101, DA},
        {3'b111, 6'b000110, CA},
        {3'b111, 6'b000110, CA},
        {3'b110, 6'b010111, 8'h00},
        {3'b011, 6'b110001, DA},
        {3'b011, 6'b011111, 8'h00},
        {3'b010, 6'b011111, 8'h00},
        {3'b010, 6'b010111, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {disp_sel, cpu_sel_n, ref_sel, sync_n, adv_n, cpu_wait};
    endfunction

    // one display access with no CPU request; the check lands after it closes
    task automatic one_disp(input logic exp_ref, input logic [AW-1:0] exp_addr, input string tag);
        @(negedge clk); disp_req = 1'b1; cpu_req = 1'b0; phase_in = 1'b0;
        @(negedge clk); disp_req = 1'b0; phase_in = 1'b1;
        @(negedge clk); phase_in = 1'b0;
        #1;
        chk(tag, {31'd0, ref_sel}, {31'd0, exp_ref});
        chk(tag, {24'd0, ram_addr}, {24'd0, exp_addr});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        chk("R9 reset outputs", {26'd0, outs()}, {26'd0, 6'b010110});
        chk("R9 reset addr", {24'd0, ram_addr}, 32'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7 R8: vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {disp_req, cpu_req, phase_in} = VEC[i][16:14];
            #1;
            chk($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 row %0d strobes", i),
                {26'd0, outs()}, {26'd0, VEC[i][13:8]});
            chk($sformatf("R2 R3 R8 row %0d addr", i),
                {24'd0, ram_addr}, {24'd0, VEC[i][7:0]});
        end

        // R7: second refresh shows the stepped counter, lasts two cycles
        one_disp(1'b0, 8'h00, "R7 no refresh 1");
        one_disp(1'b0, 8'h00, "R7 no refresh 2");
        one_disp(1'b0, 8'h00, "R7 no refresh 3");
        one_disp(1'b1, 8'h01, "R7 refresh addr");
        @(negedge clk); #1;
        chk("R7 refresh second cycle", {31'd0, ref_sel}, 32'd1);
        @(negedge clk); #1;
        chk("R7 refresh ended", {31'd0, ref_sel}, 32'd0);
        chk("R8 idle addr", {24'd0, ram_addr}, 32'd0);

        // R9: reset in the middle of a display access
        @(negedge clk); disp_req = 1'b1;
        @(negedge clk); disp_req = 1'b0; #1;
        chk("R9 display before reset", {31'd0, disp_sel}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R9 cleared by reset", {26'd0, outs()}, {26'd0, 6'b010110});

        // R9: after reset a CPU request alone grants nothing
        rst_n = 1'b1; cpu_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk("R9 no CPU before display", {30'd0, cpu_sel_n, cpu_wait}, 32'd3);
        end
        // R9: first grant is a display access
        disp_req = 1'b1;
        @(negedge clk); disp_req = 1'b0; #1;
        chk("R9 first grant display", {30'd0, disp_sel, sync_n}, 32'd2);
        // R5: phase edge closes it, CPU slot follows
        phase_in = 1'b1;
        @(negedge clk); #1;
        chk("R5 CPU after display", {30'd0, cpu_sel_n, cpu_wait}, 32'd0);
        cpu_req = 1'b0; phase_in = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule